// File: doc/BRIEF.md
# Functional-Unit Scoreboard Issue Controller

This block is the central hazard controller for a machine built around a small set of non-pipelined functional units. Instructions arrive one per cycle, in program order, through a valid/ready handshake. Each carries the index of the unit it needs, an operation code, a destination register and two source registers. The block holds exactly one window entry per unit and moves each instruction through four phases: allocation, operand read, execution and result write. It tells each unit, through single-cycle pulses, when to read its operands and when to write its result. Each unit reports the end of its computation with a one-cycle done pulse.

A register-producer table records which unit will write each architectural register. A source that matches the table is a read-after-write dependence. The entry then waits for that unit's write-back and takes the released operand as soon as it appears. A destination that matches the table is a write-after-write hazard, and it stalls allocation. Write-after-read hazards do not stall allocation. A finished unit is instead held at write-back while another unit still has that register as a ready but unread operand. The block keeps no commit stage, so interrupts are imprecise.

The register file, the arithmetic, fetch and memory access lie outside the block. The per-unit operation and register fields are exposed, so each unit can address the register file when its read pulse arrives.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset no unit is busy, `rd_go` and `wr_go` are all zero, and `iss_ready` is high for any presented instruction.
- R2: `iss_ready` is low while the unit selected by `iss_unit` is busy (structural hazard).
- R3: `iss_ready` is low while the register named by `iss_dst` has a pending producer (write-after-write). An accepted instruction makes `unit_busy[u]` high from the next cycle. Bit u of every per-unit vector belongs to unit u, and fields `unit_op`, `unit_dst`, `unit_src1` and `unit_src2` occupy slice `[u*W +: W]`, where W is the field width.
- R4: Each unit asserts `rd_go[u]` for exactly one cycle. The pulse comes in the cycle after the one in which both of the unit's operands became available, and never in the same cycle as its `wr_go[u]`.
- R5: An operand is available at allocation if its register had no pending producer. Otherwise it becomes available once that producer writes back. If the producer is granted write-back in the same cycle as the allocation, the operand counts as available at once.
- R6: `exec_done[u]` is honoured only after the unit's `rd_go[u]` pulse and before its write-back. In any other state the pulse is ignored.
- R7: A finished unit is not granted write-back while any other unit holds an available but unread operand whose source register equals the finished unit's destination.
- R8: Among finished units that are eligible in the same cycle, the lowest index is granted. `wr_go` is one-hot or zero, and a unit that is not granted keeps waiting.
- R9: `wr_go[u]` frees unit u and its destination register in the table, so `unit_busy[u]` is low in the same cycle as the pulse. Every operand waiting on unit u becomes available.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is presented |
| iss_ready | output | 1 | The presented instruction is accepted at the next edge |
| iss_unit | input | $clog2(NUM_FU) | Target functional unit index |
| iss_op | input | OP_W | Operation code passed to the unit |
| iss_dst | input | $clog2(NUM_REG) | Destination register |
| iss_src1 | input | $clog2(NUM_REG) | First source register |
| iss_src2 | input | $clog2(NUM_REG) | Second source register |
| exec_done | input | NUM_FU | Per-unit pulse: computation finished |
| rd_go | output | NUM_FU | Per-unit pulse: read operands now |
| wr_go | output | NUM_FU | Per-unit pulse: write result now |
| unit_busy | output | NUM_FU | Per-unit entry occupied |
| unit_op | output | NUM_FU*OP_W | Operation code held by each unit |
| unit_dst | output | NUM_FU*$clog2(NUM_REG) | Destination held by each unit |
| unit_src1 | output | NUM_FU*$clog2(NUM_REG) | First source held by each unit |
| unit_src2 | output | NUM_FU*$clog2(NUM_REG) | Second source held by each unit |

## Verification
A directed opening sequence is built so that one finished unit must wait for another unit's unread operand, a second instruction names a destination still pending, and a third targets a unit still in use. This tells the write-back hold apart from the two allocation stalls. A long random stream follows, with independent unit and register picks, random issue gaps and execution latencies of zero to four cycles. It produces same-cycle completions, which exercise the lowest-index choice, and allocations that coincide with the releasing write-back, which exercise the same-cycle operand release. Done pulses are also sent at random to units that are idle, waiting or finished. These pulses separate a controller that honours completion only while executing from one that lets a stray pulse advance an entry.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Life cycle of one functional-unit window entry
  typedef enum logic [1:0] {
    U_IDLE    = 2'd0,
    U_WAITOPS = 2'd1,
    U_EXEC    = 2'd2,
    U_DONE    = 2'd3
  } unit_state_t;

  // Tracking for one source operand of an entry
  typedef struct packed {
    logic avail;    // value may be read (set, not yet consumed)
    logic waiting;  // still waiting for a producing unit
  } src_track_t;

endpackage

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int UW = $clog2(NUM_FU),
  localparam int RW = $clog2(NUM_REG)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           set_en,
  input  logic [RW-1:0]                  set_reg,
  input  logic [UW-1:0]                  set_unit,
  input  logic                           clr_en,
  input  logic [RW-1:0]                  clr_reg,
  output logic [NUM_REG-1:0]             pend,
  output logic [NUM_REG-1:0][UW-1:0]     owner
);

  // One producer slot per architectural register. Allocation and release
  // never name the same register in one cycle (allocation is stalled on a
  // pending destination), so their order here is immaterial.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      owner <= '0;
    end else begin
      if (clr_en) begin
        pend[clr_reg] <= 1'b0;
      end
      if (set_en) begin
        pend[set_reg]  <= 1'b1;
        owner[set_reg] <= set_unit;
      end
    end
  end

endmodule

// File: rtl/sb_issue_check.sv
module sb_issue_check #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int UW = $clog2(NUM_FU),
  localparam int RW = $clog2(NUM_REG)
) (
  input  logic [UW-1:0]               iss_unit,
  input  logic [RW-1:0]               iss_dst,
  input  logic [RW-1:0]               iss_src1,
  input  logic [RW-1:0]               iss_src2,
  input  logic [NUM_FU-1:0]           unit_busy,
  input  logic [NUM_REG-1:0]          pend,
  input  logic [NUM_REG-1:0][UW-1:0]  owner,
  input  logic                        wb_vld,
  input  logic [UW-1:0]               wb_id,
  output logic                        ok,
  output logic [1:0]                  q_wait,
  output logic [1:0][UW-1:0]          q_id
);

  logic [1:0][RW-1:0] srcs;

  assign srcs[0] = iss_src1;
  assign srcs[1] = iss_src2;

  // Structural and write-after-write checks against registered state only
  assign ok = !unit_busy[iss_unit] && !pend[iss_dst];

  // Read-after-write lookup with same-cycle release of the producer
  for (genvar s = 0; s < 2; s++) begin : g_src
    always_comb begin
      q_id[s]   = owner[srcs[s]];
      q_wait[s] = pend[srcs[s]] && !(wb_vld && (wb_id == owner[srcs[s]]));
    end
  end

endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int OP_W = 4,
  parameter int RW   = 3,
  parameter int UW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc,
  input  logic [OP_W-1:0] a_op,
  input  logic [RW-1:0]   a_dst,
  input  logic [RW-1:0]   a_src1,
  input  logic [RW-1:0]   a_src2,
  input  logic [1:0]      a_q_wait,
  input  logic [1:0][UW-1:0] a_q_id,
  input  logic            bc_vld,
  input  logic [UW-1:0]   bc_id,
  input  logic            done_in,
  input  logic            grant,
  output logic            busy,
  output logic            wb_req,
  output logic [1:0]      src_avail,
  output logic [OP_W-1:0] op,
  output logic [RW-1:0]   fi,
  output logic [RW-1:0]   fj,
  output logic [RW-1:0]   fk,
  output logic            rd_go,
  output logic            wr_go
);

  unit_state_t          st;
  src_track_t [1:0]     trk;
  logic [1:0][UW-1:0]   qsrc;
  logic                 both_ready;

  assign both_ready = trk[0].avail && trk[1].avail;

  // Instruction fields captured on allocation
  always_ff @(posedge clk) begin
    if (rst) begin
      op <= '0;
      fi <= '0;
      fj <= '0;
      fk <= '0;
    end else if (alloc && (st == U_IDLE)) begin
      op <= a_op;
      fi <= a_dst;
      fj <= a_src1;
      fk <= a_src2;
    end
  end

  // Phase sequencing and the two handshake pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= U_IDLE;
      rd_go <= 1'b0;
      wr_go <= 1'b0;
    end else begin
      rd_go <= 1'b0;
      wr_go <= 1'b0;
      unique case (st)
        U_IDLE:    if (alloc) st <= U_WAITOPS;
        U_WAITOPS: if (both_ready) begin
                     st    <= U_EXEC;
                     rd_go <= 1'b1;
                   end
        U_EXEC:    if (done_in) st <= U_DONE;
        U_DONE:    if (grant) begin
                     st    <= U_IDLE;
                     wr_go <= 1'b1;
                   end
        default:   st <= U_IDLE;
      endcase
    end
  end

  // Per-source producer tracking, one copy per operand
  for (genvar s = 0; s < 2; s++) begin : g_trk
    always_ff @(posedge clk) begin
      if (rst) begin
        trk[s]  <= '0;
        qsrc[s] <= '0;
      end else if ((st == U_IDLE) && alloc) begin
        trk[s].waiting <= a_q_wait[s];
        trk[s].avail   <= !a_q_wait[s];
        qsrc[s]        <= a_q_id[s];
      end else if (st == U_WAITOPS) begin
        if (both_ready) begin
          trk[s].avail <= 1'b0;
        end else if (bc_vld && trk[s].waiting && (qsrc[s] == bc_id)) begin
          trk[s].avail   <= 1'b1;
          trk[s].waiting <= 1'b0;
        end
      end
    end
  end

  assign busy         = (st != U_IDLE);
  assign wb_req       = (st == U_DONE);
  assign src_avail[0] = (st == U_WAITOPS) && trk[0].avail;
  assign src_avail[1] = (st == U_WAITOPS) && trk[1].avail;

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int NUM_FU = 4,
  parameter int RW     = 3,
  localparam int UW = $clog2(NUM_FU)
) (
  input  logic [NUM_FU-1:0]          wb_req,
  input  logic [NUM_FU-1:0][RW-1:0]  fi,
  input  logic [NUM_FU-1:0][RW-1:0]  fj,
  input  logic [NUM_FU-1:0][RW-1:0]  fk,
  input  logic [NUM_FU-1:0][1:0]     src_avail,
  output logic [NUM_FU-1:0]          grant,
  output logic                       grant_vld,
  output logic [UW-1:0]              grant_id,
  output logic [RW-1:0]              grant_reg
);

  logic [NUM_FU-1:0] war_hold;
  logic [NUM_FU-1:0] eligible;

  // A finished unit waits while another unit still owes a read of its target
  for (genvar f = 0; f < NUM_FU; f++) begin : g_war
    always_comb begin
      war_hold[f] = 1'b0;
      for (int g = 0; g < NUM_FU; g++) begin
        if (g != f) begin
          if ((src_avail[g][0] && (fj[g] == fi[f])) ||
              (src_avail[g][1] && (fk[g] == fi[f]))) begin
            war_hold[f] = 1'b1;
          end
        end
      end
    end
  end

  assign eligible = wb_req & ~war_hold;

  // Fixed priority, lowest index first
  always_comb begin
    grant     = '0;
    grant_vld = 1'b0;
    grant_id  = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_vld = 1'b1;
        grant_id  = UW'(i);
      end
    end
  end

  assign grant_reg = fi[grant_id];

endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  parameter int OP_W    = 4,
  localparam int UW = $clog2(NUM_FU),
  localparam int RW = $clog2(NUM_REG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   iss_valid,
  output logic                   iss_ready,
  input  logic [UW-1:0]          iss_unit,
  input  logic [OP_W-1:0]        iss_op,
  input  logic [RW-1:0]          iss_dst,
  input  logic [RW-1:0]          iss_src1,
  input  logic [RW-1:0]          iss_src2,
  input  logic [NUM_FU-1:0]      exec_done,
  output logic [NUM_FU-1:0]      rd_go,
  output logic [NUM_FU-1:0]      wr_go,
  output logic [NUM_FU-1:0]      unit_busy,
  output logic [NUM_FU*OP_W-1:0] unit_op,
  output logic [NUM_FU*RW-1:0]   unit_dst,
  output logic [NUM_FU*RW-1:0]   unit_src1,
  output logic [NUM_FU*RW-1:0]   unit_src2
);

  logic [NUM_REG-1:0]            pend;
  logic [NUM_REG-1:0][UW-1:0]    owner;
  logic                          chk_ok;
  logic [1:0]                    q_wait;
  logic [1:0][UW-1:0]            q_id;
  logic                          accept;

  logic [NUM_FU-1:0]             e_wb_req;
  logic [NUM_FU-1:0][1:0]        e_avail;
  logic [NUM_FU-1:0][OP_W-1:0]   e_op;
  logic [NUM_FU-1:0][RW-1:0]     e_fi;
  logic [NUM_FU-1:0][RW-1:0]     e_fj;
  logic [NUM_FU-1:0][RW-1:0]     e_fk;

  logic [NUM_FU-1:0]             grant;
  logic                          grant_vld;
  logic [UW-1:0]                 grant_id;
  logic [RW-1:0]                 grant_reg;

  assign iss_ready = chk_ok;
  assign accept    = iss_valid && chk_ok;

  sb_reg_status #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .set_en   (accept),
    .set_reg  (iss_dst),
    .set_unit (iss_unit),
    .clr_en   (grant_vld),
    .clr_reg  (grant_reg),
    .pend     (pend),
    .owner    (owner)
  );

  sb_issue_check #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_check (
    .iss_unit  (iss_unit),
    .iss_dst   (iss_dst),
    .iss_src1  (iss_src1),
    .iss_src2  (iss_src2),
    .unit_busy (unit_busy),
    .pend      (pend),
    .owner     (owner),
    .wb_vld    (grant_vld),
    .wb_id     (grant_id),
    .ok        (chk_ok),
    .q_wait    (q_wait),
    .q_id      (q_id)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    sb_fu_entry #(.OP_W(OP_W), .RW(RW), .UW(UW)) u_entry (
      .clk       (clk),
      .rst       (rst),
      .alloc     (accept && (iss_unit == UW'(u))),
      .a_op      (iss_op),
      .a_dst     (iss_dst),
      .a_src1    (iss_src1),
      .a_src2    (iss_src2),
      .a_q_wait  (q_wait),
      .a_q_id    (q_id),
      .bc_vld    (grant_vld),
      .bc_id     (grant_id),
      .done_in   (exec_done[u]),
      .grant     (grant[u]),
      .busy      (unit_busy[u]),
      .wb_req    (e_wb_req[u]),
      .src_avail (e_avail[u]),
      .op        (e_op[u]),
      .fi        (e_fi[u]),
      .fj        (e_fj[u]),
      .fk        (e_fk[u]),
      .rd_go     (rd_go[u]),
      .wr_go     (wr_go[u])
    );
  end

  sb_wb_arbiter #(.NUM_FU(NUM_FU), .RW(RW)) u_arb (
    .wb_req    (e_wb_req),
    .fi        (e_fi),
    .fj        (e_fj),
    .fk        (e_fk),
    .src_avail (e_avail),
    .grant     (grant),
    .grant_vld (grant_vld),
    .grant_id  (grant_id),
    .grant_reg (grant_reg)
  );

  assign unit_op   = e_op;
  assign unit_dst  = e_fi;
  assign unit_src1 = e_fj;
  assign unit_src2 = e_fk;

endmodule

// File: rtl/sb_issue_ctrl_chk.sv
module sb_issue_ctrl_chk #(
  parameter int NUM_FU = 4,
  localparam int UW = $clog2(NUM_FU)
) (
  input logic              clk,
  input logic              rst,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [UW-1:0]     iss_unit,
  input logic [NUM_FU-1:0] unit_busy,
  input logic [NUM_FU-1:0] rd_go,
  input logic [NUM_FU-1:0] wr_go
);

  assert_struct_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && unit_busy[iss_unit]) |-> !iss_ready);

  assert_alloc_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready) |=> unit_busy[$past(iss_unit)]);

  assert_rd_single_R4: assert property (@(posedge clk) disable iff (rst)
    (|rd_go) |=> ((rd_go & $past(rd_go)) == '0));

  assert_rd_wr_apart_R4: assert property (@(posedge clk) disable iff (rst)
    ((rd_go & wr_go) == '0));

  assert_wr_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_go));

  assert_wr_from_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (|wr_go) |-> ((wr_go & ~$past(unit_busy)) == '0));

  assert_wr_frees_R9: assert property (@(posedge clk) disable iff (rst)
    (|wr_go) |-> ((wr_go & unit_busy) == '0));

endmodule

bind sb_issue_ctrl sb_issue_ctrl_chk #(.NUM_FU(NUM_FU)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_unit  (iss_unit),
  .unit_busy (unit_busy),
  .rd_go     (rd_go),
  .wr_go     (wr_go)
);

// File: tb/sb_issue_ctrl_tb.sv
module sb_issue_ctrl_tb;

  localparam int NF = 4;
  localparam int NR = 8;
  localparam int OW = 4;
  localparam int UW = 2;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          iss_valid = 1'b0;
  logic          iss_ready;
  logic [UW-1:0] iss_unit = '0;
  logic [OW-1:0] iss_op = '0;
  logic [RW-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic [NF-1:0] exec_done = '0;
  logic [NF-1:0] rd_go, wr_go, unit_busy;
  logic [NF*OW-1:0] unit_op;
  logic [NF*RW-1:0] unit_dst, unit_src1, unit_src2;

  sb_issue_ctrl u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_unit(iss_unit), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .exec_done(exec_done),
    .rd_go(rd_go), .wr_go(wr_go), .unit_busy(unit_busy), .unit_op(unit_op),
    .unit_dst(unit_dst), .unit_src1(unit_src1), .unit_src2(unit_src2)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench model of every unit (0 idle, 1 waiting operands, 2 executing, 3 finished)
  int b_st[NF], b_dst[NF], b_s1[NF], b_s2[NF], b_op[NF], b_lat[NF], b_left[NF];
  int b_q1[NF], b_q2[NF];
  bit b_q1w[NF], b_q2w[NF], b_drv[NF];
  bit b_pend[NR];
  int b_own[NR];
  bit exp_rd[NF], exp_wr[NF];

  // Presented and accepted instruction
  bit have = 1'b0;
  int c_u, c_d, c_s1, c_s2, c_op, c_lat;
  bit acc = 1'b0;
  int a_u, a_d, a_s1, a_s2, a_op, a_lat, a_q1, a_q2;
  bit a_q1w, a_q2w;

  // Directed opening sequence
  int d_u[5]   = '{1, 2, 0, 3, 1};
  int d_d[5]   = '{4, 6, 1, 4, 2};
  int d_s1[5]  = '{0, 4, 0, 2, 6};
  int d_s2[5]  = '{0, 1, 0, 2, 1};
  int d_lat[5] = '{3, 0, 0, 0, 1};
  int d_idx = 0;

  int cov_struct = 0, cov_waw = 0, cov_bypass = 0, cov_war = 0, cov_multi = 0, cov_spur = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic new_instr();
    if (d_idx < 5) begin
      c_u = d_u[d_idx]; c_d = d_d[d_idx]; c_s1 = d_s1[d_idx]; c_s2 = d_s2[d_idx];
      c_lat = d_lat[d_idx]; c_op = d_idx + 1;
      d_idx++;
    end else begin
      c_u = $urandom % NF; c_d = $urandom % NR;
      c_s1 = $urandom % NR; c_s2 = $urandom % NR;
      c_lat = $urandom % 5; c_op = $urandom % 16;
    end
    have = 1'b1;
  endtask

  task automatic step(input bit allow_issue);
    int issued_u;
    int n_elig;
    logic [NF-1:0] ed;
    @(negedge clk);
    // Compare the pulses predicted one cycle ago
    for (int u = 0; u < NF; u++) begin
      chk($sformatf("R4 R5 rd_go unit %0d", u), int'(rd_go[u]), int'(exp_rd[u]));
      chk($sformatf("R7 R8 wr_go unit %0d", u), int'(wr_go[u]), int'(exp_wr[u]));
    end
    // Allocation taken at the last edge
    issued_u = -1;
    if (acc) begin
      b_st[a_u] = 1; b_dst[a_u] = a_d; b_s1[a_u] = a_s1; b_s2[a_u] = a_s2;
      b_op[a_u] = a_op; b_lat[a_u] = a_lat;
      b_q1w[a_u] = a_q1w; b_q1[a_u] = a_q1; b_q2w[a_u] = a_q2w; b_q2[a_u] = a_q2;
      b_pend[a_d] = 1'b1; b_own[a_d] = a_u;
      issued_u = a_u;
      acc = 1'b0;
    end
    // Write-backs: free unit, register, and waiting operands (R9, R5 bypass)
    for (int u = 0; u < NF; u++) begin
      if (exp_wr[u]) begin
        b_st[u] = 0;
        b_pend[b_dst[u]] = 1'b0;
        for (int g = 0; g < NF; g++) begin
          if (b_st[g] == 1 && b_q1w[g] && b_q1[g] == u) begin
            b_q1w[g] = 1'b0;
            if (g == issued_u) cov_bypass++;
          end
          if (b_st[g] == 1 && b_q2w[g] && b_q2[g] == u) begin
            b_q2w[g] = 1'b0;
            if (g == issued_u) cov_bypass++;
          end
        end
      end
    end
    for (int u = 0; u < NF; u++) begin
      if (exp_rd[u]) begin
        b_st[u] = 2;
        b_left[u] = b_lat[u];
      end
    end
    for (int u = 0; u < NF; u++) begin
      if (b_drv[u]) begin
        b_drv[u] = 1'b0;
        if (b_st[u] == 2) b_st[u] = 3;
      end
    end
    // Occupancy and captured fields (R3, R9)
    for (int u = 0; u < NF; u++) begin
      chk($sformatf("R3 R9 unit_busy %0d", u), int'(unit_busy[u]), int'(b_st[u] != 0));
      if (b_st[u] != 0) begin
        chk($sformatf("R3 unit_dst %0d", u), int'(unit_dst[u*RW +: RW]), b_dst[u]);
        chk($sformatf("R3 unit_src1 %0d", u), int'(unit_src1[u*RW +: RW]), b_s1[u]);
        chk($sformatf("R3 unit_src2 %0d", u), int'(unit_src2[u*RW +: RW]), b_s2[u]);
        chk($sformatf("R3 unit_op %0d", u), int'(unit_op[u*OW +: OW]), b_op[u]);
      end
    end
    // Unit behaviour: done after the latency, stray pulses elsewhere (R6)
    for (int u = 0; u < NF; u++) begin
      ed[u] = 1'b0;
      if (b_st[u] == 2) begin
        if (b_left[u] == 0) begin
          ed[u] = 1'b1;
          b_drv[u] = 1'b1;
        end else begin
          b_left[u]--;
        end
      end else if ($urandom % 6 == 0) begin
        ed[u] = 1'b1;
        cov_spur++;
      end
    end
    exec_done = ed;
    // Present an instruction
    if (!have && allow_issue && ($urandom % 4 != 0)) new_instr();
    iss_valid = have;
    iss_unit = UW'(c_u); iss_dst = RW'(c_d); iss_src1 = RW'(c_s1);
    iss_src2 = RW'(c_s2); iss_op = OW'(c_op);
    #1;
    if (have) begin
      bit er;
      er = (b_st[c_u] == 0) && !b_pend[c_d];
      if (b_st[c_u] != 0) cov_struct++;
      else if (b_pend[c_d]) cov_waw++;
      chk("R2 R3 iss_ready", int'(iss_ready), int'(er));
      if (er) begin
        acc = 1'b1;
        a_u = c_u; a_d = c_d; a_s1 = c_s1; a_s2 = c_s2; a_op = c_op; a_lat = c_lat;
        a_q1w = b_pend[c_s1]; a_q1 = b_own[c_s1];
        a_q2w = b_pend[c_s2]; a_q2 = b_own[c_s2];
        have = 1'b0;
      end
    end
    // Predict the next edge
    n_elig = 0;
    for (int u = 0; u < NF; u++) begin
      exp_rd[u] = (b_st[u] == 1) && !b_q1w[u] && !b_q2w[u];
      exp_wr[u] = 1'b0;
    end
    for (int u = 0; u < NF; u++) begin
      if (b_st[u] == 3) begin
        bit hold;
        hold = 1'b0;
        for (int g = 0; g < NF; g++) begin
          if (g != u && b_st[g] == 1 &&
              ((!b_q1w[g] && b_s1[g] == b_dst[u]) || (!b_q2w[g] && b_s2[g] == b_dst[u])))
            hold = 1'b1;
        end
        if (hold) cov_war++;
        else begin
          if (n_elig == 0) exp_wr[u] = 1'b1;
          n_elig++;
        end
      end
    end
    if (n_elig > 1) cov_multi++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int u = 0; u < NF; u++) begin
      b_st[u] = 0; b_drv[u] = 1'b0; exp_rd[u] = 1'b0; exp_wr[u] = 1'b0;
      b_q1w[u] = 1'b0; b_q2w[u] = 1'b0;
    end
    for (int r = 0; r < NR; r++) begin
      b_pend[r] = 1'b0; b_own[r] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state with an instruction presented
    @(negedge clk);
    iss_valid = 1'b1; iss_unit = 2'd3; iss_dst = 3'd5;
    #1;
    chk("R1 iss_ready after reset", int'(iss_ready), 1);
    chk("R1 unit_busy after reset", int'(unit_busy), 0);
    chk("R1 rd_go after reset", int'(rd_go), 0);
    chk("R1 wr_go after reset", int'(wr_go), 0);
    iss_valid = 1'b0;
    // Directed sequence first, then random traffic
    for (int i = 0; i < 3000; i++) step(1'b1);
    for (int i = 0; i < 80; i++) step(1'b0);
    chk("R9 all units free after drain", int'(unit_busy), 0);
    chk("R2 structural stall seen", int'(cov_struct > 0), 1);
    chk("R3 destination stall seen", int'(cov_waw > 0), 1);
    chk("R5 same-cycle release seen", int'(cov_bypass > 0), 1);
    chk("R6 stray done pulses sent", int'(cov_spur > 0), 1);
    chk("R7 write-back hold seen", int'(cov_war > 0), 1);
    chk("R8 contended write-back seen", int'(cov_multi > 0), 1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule